// File: doc/BRIEF.md
# Configurable Quadrature Decoder Counter

This block turns an encoder's two phase signals, an index pulse and a strobe pulse into a 32-bit position count. All four inputs must already be synchronised to the system clock. Each input can be inverted on its own. The two phase inputs can also be exchanged before decoding. A 2-bit mode field selects how phase edges turn into counts: full quadrature, clock plus direction, up-only or down-only.

Software drives a small write port with an address and data. Through it, it sets the mode, polarity and swap controls, and it loads the counter's limit, its reload value or the count itself. The count wraps between zero and a programmable maximum. A rising index edge copies the current count into a latch. A quadrature step where both phases change in the same cycle is dropped and raises a sticky error flag.

Top module: `quad_counter`

## Requirements
- R1: After reset the position, the index latch and the phase-error flag are all 0, the maximum is all ones, and counting is disabled.
- R2: Register map (address: meaning): 0 control, 1 reload value, 2 maximum, 3 direct position value, 4 command. Addresses 5 to 7 are ignored. Control bits: [0] enable, [2:1] mode, [3] swap, [4] invert A, [5] invert B, [6] invert index, [7] invert strobe. In mode 0 (quadrature), each single-phase change where A leads B adds one, and each where B leads A subtracts one. A leads B when the phase pair steps through 00, 10, 11, 01 (written AB).
- R3: In mode 0, a cycle in which both phases change leaves the position unchanged and sets the phase-error flag. The flag stays set until a write to address 4 with bit 1 set clears it.
- R4: In mode 1 (direction), every change of A counts one step. The step is up when B is 1 and down when B is 0. Changes of B alone do not count.
- R5: In mode 2 (up) every rising edge of A adds one, and in mode 3 (down) every rising edge of A subtracts one. Falling edges of A do not count in either mode.
- R6: With the swap bit set, the inverted-as-configured A and B inputs exchange roles before decoding.
- R7: Each invert bit flips its input before use. The conditioned strobe level appears combinationally on `strb_lvl`.
- R8: A write to address 4 with bit 0 set loads the position from the reload value.
- R9: Counting up from a position at or above the maximum gives 0. Counting down from 0 gives the maximum.
- R10: While enabled, a rising edge of the conditioned index copies the position held before that cycle's update into the index latch. A steady index level does not latch again.
- R11: While the enable bit is clear, the position, the index latch and the phase-error flag do not change, except through register writes.
- R12: A write to address 3 sets the position to the written value on the next clock. A register write wins over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Phase A, synchronised |
| in_b | input | 1 | Phase B, synchronised |
| in_idx | input | 1 | Index pulse, synchronised |
| in_strb | input | 1 | Strobe pulse, synchronised |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| position | output | 32 | Position count |
| idx_latch | output | 32 | Position captured on index |
| phase_err | output | 1 | Sticky quadrature phase error |
| strb_lvl | output | 1 | Conditioned strobe level |

## Verification
The assertions check, on every cycle, the properties that hold in any mode:
- the position moves by at most one step or wraps;
- the position holds while disabled;
- the error flag stays set until it is cleared;
- the index latch only ever takes the previous position;
- a direct write lands on the next clock.

Which direction a given edge pattern counts depends on the mode, the swap bit and the invert bits. Only the bench's scenarios show this, with the bench model following every clock. The same holds for the one-cycle count caused by changing an invert bit, and for the exact wrap values.

// File: rtl/quad_counter.sv
module quad_counter #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          in_idx,
  input  logic          in_strb,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  position,
  output logic [W-1:0]  idx_latch,
  output logic          phase_err,
  output logic          strb_lvl
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_INIT = AW'(1);
  localparam logic [AW-1:0] A_MAX  = AW'(2);
  localparam logic [AW-1:0] A_POS  = AW'(3);
  localparam logic [AW-1:0] A_CMD  = AW'(4);

  logic         en, swap;
  logic [1:0]   mode;
  logic [3:0]   inv;
  logic [W-1:0] pos_init, pos_max;
  logic         pa, pb, pi;

  logic a_p, b_p, a_c, b_c, i_c, a_chg, b_chg, quad_up, step_up, step_dn;
  logic [W-1:0] pos_inc, pos_dec;

  assign a_p      = in_a ^ inv[0];
  assign b_p      = in_b ^ inv[1];
  assign i_c      = in_idx ^ inv[2];
  assign strb_lvl = in_strb ^ inv[3];
  assign a_c      = swap ? b_p : a_p;
  assign b_c      = swap ? a_p : b_p;
  assign a_chg    = a_c ^ pa;
  assign b_chg    = b_c ^ pb;
  assign quad_up  = (a_chg & ~b_chg & (a_c ^ b_c)) | (b_chg & ~a_chg & ~(a_c ^ b_c));

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    case (mode)
      2'd0: begin
        step_up = quad_up;
        step_dn = (a_chg ^ b_chg) & ~quad_up;
      end
      2'd1: begin
        step_up = a_chg & b_c;
        step_dn = a_chg & ~b_c;
      end
      2'd2: step_up = a_c & ~pa;
      default: step_dn = a_c & ~pa;
    endcase
  end

  assign pos_inc = (position >= pos_max) ? '0 : position + W'(1);
  assign pos_dec = (position == '0) ? pos_max : position - W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      swap      <= 1'b0;
      mode      <= 2'd0;
      inv       <= 4'd0;
      pos_init  <= '0;
      pos_max   <= '1;
      position  <= '0;
      idx_latch <= '0;
      phase_err <= 1'b0;
      pa        <= 1'b0;
      pb        <= 1'b0;
      pi        <= 1'b0;
    end else begin
      pa <= a_c;
      pb <= b_c;
      pi <= i_c;
      if (en) begin
        if (step_up)      position <= pos_inc;
        else if (step_dn) position <= pos_dec;
        if (i_c && !pi)   idx_latch <= position;
        if (mode == 2'd0 && a_chg && b_chg) phase_err <= 1'b1;
      end
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            en   <= wr_data[0];
            mode <= wr_data[2:1];
            swap <= wr_data[3];
            inv  <= wr_data[7:4];
          end
          A_INIT: pos_init <= wr_data;
          A_MAX:  pos_max  <= wr_data;
          A_POS:  position <= wr_data;
          A_CMD: begin
            if (wr_data[0]) position  <= pos_init;
            if (wr_data[1]) phase_err <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module quad_counter_chk #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          en,
  input logic [W-1:0]  pos_max,
  input logic [W-1:0]  position,
  input logic [W-1:0]  idx_latch,
  input logic          phase_err
);
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_en) |=> (position == $past(position) ||
                        position == $past(position) + W'(1) ||
                        position == $past(position) - W'(1) ||
                        position == '0 || position == $past(pos_max)));

  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(position) && $stable(idx_latch)));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !(wr_en && wr_addr == AW'(4) && wr_data[1])) |=> phase_err);

  assert_latch_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_latch != $past(idx_latch)) |-> (idx_latch == $past(position)));

  assert_direct_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(3)) |=> (position == $past(wr_data)));
endmodule

bind quad_counter quad_counter_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en(en), .pos_max(pos_max), .position(position), .idx_latch(idx_latch),
  .phase_err(phase_err)
);

// File: tb/quad_counter_bench.sv
`timescale 1ns/1ps
module quad_counter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 0, in_b = 0, in_idx = 0, in_strb = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] position, idx_latch;
  logic phase_err, strb_lvl;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_counter u_quad_counter (.*);

  logic [31:0] m_pos, m_lat, m_init, m_max;
  logic m_perr, m_en, m_sw, m_pa, m_pb, m_pi;
  logic [1:0] m_mode;
  logic [3:0] m_inv;

  function automatic int ph(logic a, logic b);
    if (!a && !b) return 0;
    if (a && !b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_lat = 0; m_init = 0; m_max = 32'hFFFF_FFFF;
      m_perr = 0; m_en = 0; m_sw = 0; m_pa = 0; m_pb = 0; m_pi = 0;
      m_mode = 0; m_inv = 0;
    end else begin
      logic ra, rb, ca, cb, ci;
      bit up, dn;
      int d;
      ra = in_a ^ m_inv[0]; rb = in_b ^ m_inv[1]; ci = in_idx ^ m_inv[2];
      ca = m_sw ? rb : ra;  cb = m_sw ? ra : rb;
      up = 0; dn = 0;
      case (m_mode)
        0: begin
          d = (ph(ca, cb) - ph(m_pa, m_pb) + 4) % 4;
          up = (d == 1); dn = (d == 3);
          if (d == 2 && m_en) m_perr = 1;
        end
        1: if (ca != m_pa) begin if (cb) up = 1; else dn = 1; end
        2: up = ca && !m_pa;
        default: dn = ca && !m_pa;
      endcase
      if (m_en) begin
        if (ci && !m_pi) m_lat = m_pos;
        if (up)      m_pos = (m_pos >= m_max) ? 0 : m_pos + 1;
        else if (dn) m_pos = (m_pos == 0) ? m_max : m_pos - 1;
      end
      m_pa = ca; m_pb = cb; m_pi = ci;
      if (wr_en) case (wr_addr)
        0: begin m_en = wr_data[0]; m_mode = wr_data[2:1]; m_sw = wr_data[3]; m_inv = wr_data[7:4]; end
        1: m_init = wr_data;
        2: m_max = wr_data;
        3: m_pos = wr_data;
        4: begin if (wr_data[0]) m_pos = m_init; if (wr_data[1]) m_perr = 0; end
        default: ;
      endcase
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2-R12 model position", position, m_pos);
    chk("R10 model index latch", idx_latch, m_lat);
    chk("R3 model phase error", {31'd0, phase_err}, {31'd0, m_perr});
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ab(logic a, logic b);
    in_a = a; in_b = b;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset position", position, 0);
    chk("R1 reset latch", idx_latch, 0);
    chk("R1 reset phase error", {31'd0, phase_err}, 0);
    ab(1, 0); ab(0, 0);
    chk("R1 disabled after reset", position, 0);

    wr(0, 1); wr(3, 0);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    chk("R2 A leads counts up", position, 4);
    ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0); ab(0, 1); ab(1, 1);
    chk("R2 R9 B leads counts down through zero", position, 32'hFFFF_FFFE);
    ab(0, 0);
    chk("R3 both phases change no count", position, 32'hFFFF_FFFE);
    chk("R3 phase error set", {31'd0, phase_err}, 1);
    idle(2);
    chk("R3 phase error sticky", {31'd0, phase_err}, 1);
    wr(4, 2);
    chk("R3 phase error cleared", {31'd0, phase_err}, 0);

    wr(2, 9); wr(3, 9);
    chk("R12 direct position write", position, 9);
    ab(1, 0);
    chk("R9 up wraps from max", position, 0);
    ab(0, 0);
    chk("R9 down wraps to max", position, 9);
    wr(2, 1000);

    wr(0, 3); wr(3, 0);
    ab(0, 1); ab(1, 1); ab(0, 1); ab(1, 1);
    chk("R4 direction up with B high", position, 3);
    ab(1, 0); ab(0, 0); ab(1, 0);
    chk("R4 direction down with B low", position, 1);

    wr(0, 5); wr(3, 0);
    ab(0, 0); ab(1, 0); ab(0, 0); ab(1, 0);
    chk("R5 up mode rising edges only", position, 2);
    wr(0, 7); wr(3, 10);
    ab(0, 0); ab(1, 0); ab(0, 0); ab(1, 0);
    chk("R5 down mode rising edges only", position, 8);
    ab(0, 0);

    wr(0, 9); wr(3, 0);
    ab(0, 1); ab(1, 1);
    chk("R6 swapped B lead counts up", position, 2);
    ab(1, 0); ab(0, 0);
    chk("R6 swapped sequence continues up", position, 4);

    wr(0, 21); idle(1); wr(3, 0);
    ab(1, 0); ab(0, 0);
    chk("R7 inverted A counts on physical fall", position, 1);
    wr(0, 149);
    in_strb = 0; #1;
    chk("R7 strobe inverted", {31'd0, strb_lvl}, 1);
    in_strb = 1; #1;
    chk("R7 strobe inverted high", {31'd0, strb_lvl}, 0);
    in_strb = 0;
    @(negedge clk);

    wr(0, 1); idle(1); wr(3, 77);
    in_idx = 1; @(negedge clk);
    chk("R10 index rising latches", idx_latch, 77);
    wr(3, 5); idle(2);
    chk("R10 steady index no relatch", idx_latch, 77);
    in_idx = 0; @(negedge clk);

    wr(1, 123); wr(4, 1);
    chk("R8 software init load", position, 123);

    wr(0, 0);
    ab(1, 0); ab(1, 1);
    chk("R11 disabled position holds", position, 123);
    in_idx = 1; @(negedge clk);
    chk("R11 disabled no latch", idx_latch, 77);
    ab(0, 0);
    chk("R11 disabled no phase error", {31'd0, phase_err}, 0);
    in_idx = 0; idle(2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule